// File: doc/BRIEF.md
# Burst Prefetch Serializer

This block sits between a slow, wide memory core and a fast, narrow pin interface. Each accepted read command fetches one wide word, RATIO beats of BEAT_W bits taken from a single row, in one core access. It then streams that word out as RATIO beats in ascending column order. The interface is double data rate, so two beats leave per clock on a low lane and a high lane, and a burst takes RATIO/2 clocks. The long core access delay, CORE_LAT clocks, is paid once per burst and not once per beat.

Every access is a full burst. The requester gives an inclusive start and end column offset inside the burst. Each beat carries a used flag, and beats outside that range are still sent with the flag clear so that the receiver can drop them. A write port fills the core model with wide words.

Top module: `burst_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it, cmdReady is 1 and outValid, outLast, outUsedLo and outUsedHi are 0.
- R2: A command is taken on a rising edge where cmdValid and cmdReady are both 1. From that edge until the burst ends, cmdReady is 0, and any command presented in that time has no effect on the data or on the number of pairs sent.
- R3: outValid is 0 for the first CORE_LAT clocks after the accepting edge and rises exactly CORE_LAT clocks after it.
- R4: Pair k (k = 0 .. RATIO/2-1) is shown in the k-th clock of the burst. The low lane carries beat 2k and the high lane carries beat 2k+1, where beat b is bits [b*BEAT_W +: BEAT_W] of the wide word stored at cmdAddr.
- R5: A burst is exactly RATIO/2 consecutive clocks of outValid, and outLast is 1 only on the final pair.
- R6: The used flag of beat b is 1 exactly when cmdStart <= b <= cmdEnd, with both offsets being unsigned beat indices in the range 0 .. RATIO-1.
- R7: When cmdStart > cmdEnd, every beat of the burst is still sent, and no beat has its used flag set.
- R8: In the clock right after the final pair, outValid is 0 and cmdReady is 1, so a new command can be accepted with no gap.
- R9: A write to the core takes effect on its clock edge. If it hits the address of a burst on the same edge that the burst captures its word, the burst carries the old content and later reads see the new content.
- R10: RATIO is one of 2, 4 or 8 (default 8), and any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Read command present |
| cmdReady | output | 1 | Block can take a command |
| cmdAddr | input | ADDR_W | Wide word address in the core |
| cmdStart | input | OFF_W | First wanted beat offset |
| cmdEnd | input | OFF_W | Last wanted beat offset |
| memWrEn | input | 1 | Core write strobe |
| memWrAddr | input | ADDR_W | Core write address |
| memWrData | input | RATIO*BEAT_W | Core write word |
| outValid | output | 1 | A beat pair is on the lanes |
| outLast | output | 1 | Final pair of the burst |
| outBeatLo | output | BEAT_W | Even beat of the pair |
| outBeatHi | output | BEAT_W | Odd beat of the pair |
| outUsedLo | output | 1 | Even beat is within the requested range |
| outUsedHi | output | 1 | Odd beat is within the requested range |

## Verification
There are two cases where two functions can meet in one cycle. The first is a core write that lands on the same edge as a capture of that same address. The second is a new command presented in the last pair's clock, just as the block becomes free again. The bench drives a write to the burst's own address in the clock before the capture edge. It expects the old word in that burst and the new word in a later read of the address. It also holds a stray command high through each burst, then issues the next real command in the very first cycle of readiness. It judges that the stray command changed nothing and that the real one was accepted with no gap.

// File: rtl/burst_ser_pkg.sv
package burst_ser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } serState_e;

  typedef struct packed {
    logic accept;   // command taken this edge
    logic load;     // capture wide word from core this edge
    logic sending;  // a pair is on the lanes
    logic last;     // the pair on the lanes is the final one
  } serStrobe_t;

endpackage

// File: rtl/burst_ser_ctrl.sv
module burst_ser_ctrl
  import burst_ser_pkg::*;
#(
  parameter int RATIO    = 8,
  parameter int CORE_LAT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  output serStrobe_t strb
);

  localparam int PAIRS  = RATIO / 2;
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int LAT_W  = $clog2(CORE_LAT + 1);

  serState_e          stateQ;
  logic [LAT_W-1:0]   latCnt;
  logic [PAIR_W-1:0]  pairCnt;

  always_comb begin
    cmdReady     = (stateQ == ST_IDLE);
    strb.accept  = cmdValid && (stateQ == ST_IDLE);
    strb.load    = (stateQ == ST_WAIT) && (latCnt == '0);
    strb.sending = (stateQ == ST_SEND);
    strb.last    = (stateQ == ST_SEND) && (pairCnt == PAIR_W'(PAIRS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      latCnt  <= '0;
      pairCnt <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (strb.accept) begin
            stateQ <= ST_WAIT;
            latCnt <= LAT_W'(CORE_LAT - 1);
          end
        end
        ST_WAIT: begin
          if (strb.load) begin
            stateQ  <= ST_SEND;
            pairCnt <= '0;
          end else begin
            latCnt <= latCnt - 1'b1;
          end
        end
        ST_SEND: begin
          if (strb.last) begin
            stateQ <= ST_IDLE;
          end else begin
            pairCnt <= pairCnt + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_ser_dp.sv
module burst_ser_dp
  import burst_ser_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int RATIO  = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  serStrobe_t                 strb,
  input  logic [$clog2(DEPTH)-1:0]   cmdAddr,
  input  logic [$clog2(RATIO)-1:0]   cmdStart,
  input  logic [$clog2(RATIO)-1:0]   cmdEnd,
  input  logic                       memWrEn,
  input  logic [$clog2(DEPTH)-1:0]   memWrAddr,
  input  logic [RATIO*BEAT_W-1:0]    memWrData,
  output logic [BEAT_W-1:0]          outBeatLo,
  output logic [BEAT_W-1:0]          outBeatHi,
  output logic                       outUsedLo,
  output logic                       outUsedHi
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OFF_W  = $clog2(RATIO);
  localparam int WORD_W = RATIO * BEAT_W;

  logic [WORD_W-1:0] coreMem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [OFF_W-1:0]  startQ;
  logic [OFF_W-1:0]  endQ;
  logic [WORD_W-1:0] bufQ;
  logic [OFF_W-1:0]  baseQ;
  logic [OFF_W:0]    loIdx;
  logic [OFF_W:0]    hiIdx;
  logic              loIn;
  logic              hiIn;

  // core array: written from the fill port, read only at capture
  always_ff @(posedge clk) begin
    if (memWrEn) coreMem[memWrAddr] <= memWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      startQ <= '0;
      endQ   <= '0;
    end else if (strb.accept) begin
      addrQ  <= cmdAddr;
      startQ <= cmdStart;
      endQ   <= cmdEnd;
    end
  end

  // wide prefetch buffer, drained two beats per clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ  <= '0;
      baseQ <= '0;
    end else if (strb.load) begin
      bufQ  <= coreMem[addrQ];
      baseQ <= '0;
    end else if (strb.sending && !strb.last) begin
      bufQ  <= bufQ >> (2 * BEAT_W);
      baseQ <= baseQ + OFF_W'(2);
    end
  end

  always_comb begin
    loIdx = {1'b0, baseQ};
    hiIdx = loIdx + 1'b1;
    loIn  = ({1'b0, startQ} <= loIdx) && (loIdx <= {1'b0, endQ});
    hiIn  = ({1'b0, startQ} <= hiIdx) && (hiIdx <= {1'b0, endQ});
    outBeatLo = strb.sending ? bufQ[BEAT_W-1:0]        : '0;
    outBeatHi = strb.sending ? bufQ[2*BEAT_W-1:BEAT_W] : '0;
    outUsedLo = strb.sending && loIn;
    outUsedHi = strb.sending && hiIn;
  end

endmodule

// File: rtl/burst_serializer.sv
module burst_serializer
  import burst_ser_pkg::*;
#(
  parameter int BEAT_W   = 8,
  parameter int RATIO    = 8,
  parameter int DEPTH    = 16,
  parameter int CORE_LAT = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  output logic                       cmdReady,
  input  logic [$clog2(DEPTH)-1:0]   cmdAddr,
  input  logic [$clog2(RATIO)-1:0]   cmdStart,
  input  logic [$clog2(RATIO)-1:0]   cmdEnd,
  input  logic                       memWrEn,
  input  logic [$clog2(DEPTH)-1:0]   memWrAddr,
  input  logic [RATIO*BEAT_W-1:0]    memWrData,
  output logic                       outValid,
  output logic                       outLast,
  output logic [BEAT_W-1:0]          outBeatLo,
  output logic [BEAT_W-1:0]          outBeatHi,
  output logic                       outUsedLo,
  output logic                       outUsedHi
);

  // R10: only the prefetch ratios 2, 4 and 8 are legal
  generate
    if (RATIO != 2 && RATIO != 4 && RATIO != 8) begin : g_badRatio
      $error("burst_serializer: RATIO must be 2, 4 or 8");
    end
  endgenerate

  serStrobe_t strb;

  burst_ser_ctrl #(
    .RATIO   (RATIO),
    .CORE_LAT(CORE_LAT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdReady(cmdReady),
    .strb    (strb)
  );

  burst_ser_dp #(
    .BEAT_W(BEAT_W),
    .RATIO (RATIO),
    .DEPTH (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdAddr  (cmdAddr),
    .cmdStart (cmdStart),
    .cmdEnd   (cmdEnd),
    .memWrEn  (memWrEn),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData),
    .outBeatLo(outBeatLo),
    .outBeatHi(outBeatHi),
    .outUsedLo(outUsedLo),
    .outUsedHi(outUsedHi)
  );

  assign outValid = strb.sending;
  assign outLast  = strb.last;

endmodule

// File: rtl/burst_serializer_chk.sv
module burst_serializer_chk #(
  parameter int RATIO    = 8,
  parameter int CORE_LAT = 4
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic outValid,
  input logic outLast,
  input logic outUsedLo,
  input logic outUsedHi
);

  localparam int PAIRS = RATIO / 2;

  logic [15:0] sinceAcc;
  logic [15:0] pairSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAcc <= '0;
      pairSeen <= '0;
    end else begin
      if (cmdValid && cmdReady)  sinceAcc <= 16'd1;
      else if (outValid)         sinceAcc <= '0;
      else if (sinceAcc != '0)   sinceAcc <= sinceAcc + 16'd1;
      pairSeen <= outValid ? pairSeen + 16'd1 : '0;
    end
  end

  p_busy_refuses_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !cmdReady);

  p_early_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceAcc != '0 && sinceAcc < 16'(CORE_LAT)) |=> !outValid);

  p_latency_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceAcc == 16'(CORE_LAT)) |=> outValid);

  p_last_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (pairSeen == 16'(PAIRS - 1)));

  p_full_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pairSeen < 16'(PAIRS - 1)) |=> outValid);

  p_used_in_burst_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outUsedLo || outUsedHi) |-> outValid);

  p_gapless_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> (!outValid && cmdReady));

endmodule

bind burst_serializer burst_serializer_chk #(
  .RATIO   (RATIO),
  .CORE_LAT(CORE_LAT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .outValid (outValid),
  .outLast  (outLast),
  .outUsedLo(outUsedLo),
  .outUsedHi(outUsedHi)
);

// File: tb/burst_serializer_tb.sv
module burst_serializer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BEAT_W     = 8;
  localparam int RATIO      = 8;
  localparam int DEPTH      = 16;
  localparam int CORE_LAT   = 4;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int OFF_W      = $clog2(RATIO);
  localparam int WORD_W     = RATIO * BEAT_W;
  localparam int PAIRS      = RATIO / 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdValid;
  logic              cmdReady;
  logic [ADDR_W-1:0] cmdAddr;
  logic [OFF_W-1:0]  cmdStart;
  logic [OFF_W-1:0]  cmdEnd;
  logic              memWrEn;
  logic [ADDR_W-1:0] memWrAddr;
  logic [WORD_W-1:0] memWrData;
  logic              outValid;
  logic              outLast;
  logic [BEAT_W-1:0] outBeatLo;
  logic [BEAT_W-1:0] outBeatHi;
  logic              outUsedLo;
  logic              outUsedHi;

  logic [WORD_W-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_serializer #(
    .BEAT_W(BEAT_W), .RATIO(RATIO), .DEPTH(DEPTH), .CORE_LAT(CORE_LAT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdStart(cmdStart), .cmdEnd(cmdEnd),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .outValid(outValid), .outLast(outLast),
    .outBeatLo(outBeatLo), .outBeatHi(outBeatHi),
    .outUsedLo(outUsedLo), .outUsedHi(outUsedHi)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [BEAT_W-1:0] beatOf(logic [WORD_W-1:0] w, int b);
    return w[b*BEAT_W +: BEAT_W];
  endfunction

  function automatic logic usedOf(int b, int s, int e);
    return (s <= b) && (b <= e);
  endfunction

  // called just after a falling edge; returns just after a falling edge
  task automatic writeWord(int a, logic [WORD_W-1:0] d);
    memWrEn = 1'b1; memWrAddr = ADDR_W'(a); memWrData = d;
    @(posedge clk); @(negedge clk);
    memWrEn = 1'b0;
    model[a] = d;
  endtask

  task automatic doRead(int a, int s, int e, bit midWrite);
    logic [WORD_W-1:0] expWord;
    logic [WORD_W-1:0] newWord;
    expWord = model[a];
    newWord = {$urandom, $urandom};
    chk("R8 ready before command", {63'd0, cmdReady}, 64'd1);
    cmdValid = 1'b1; cmdAddr = ADDR_W'(a);
    cmdStart = OFF_W'(s); cmdEnd = OFF_W'(e);
    @(posedge clk);
    for (int j = 0; j < CORE_LAT + PAIRS; j++) begin
      @(negedge clk);
      // R2: stray command held during the burst, different address and range
      if (j == 0) begin
        cmdValid = 1'b1; cmdAddr = ADDR_W'(a + 1);
        cmdStart = OFF_W'(e); cmdEnd = OFF_W'(s);
      end
      if (j == CORE_LAT + PAIRS - 1) cmdValid = 1'b0;
      if (midWrite && j == CORE_LAT - 1) begin
        memWrEn = 1'b1; memWrAddr = ADDR_W'(a); memWrData = newWord;
      end
      if (midWrite && j == CORE_LAT) begin
        memWrEn = 1'b0;
        model[a] = newWord;
      end
      chk("R2 busy refuses", {63'd0, cmdReady}, 64'd0);
      if (j < CORE_LAT) begin
        chk("R3 quiet before latency", {63'd0, outValid}, 64'd0);
      end else begin
        int k;
        k = j - CORE_LAT;
        chk("R3 valid at latency", {63'd0, outValid}, 64'd1);
        chk("R4 low lane beat",  {56'd0, outBeatLo}, {56'd0, beatOf(expWord, 2*k)});
        chk("R4 high lane beat", {56'd0, outBeatHi}, {56'd0, beatOf(expWord, 2*k+1)});
        chk("R6 used low",  {63'd0, outUsedLo}, {63'd0, usedOf(2*k, s, e)});
        chk("R6 used high", {63'd0, outUsedHi}, {63'd0, usedOf(2*k+1, s, e)});
        chk("R5 last flag", {63'd0, outLast}, {63'd0, (k == PAIRS - 1)});
      end
    end
    @(negedge clk);
    chk("R8 idle after last pair", {63'd0, outValid}, 64'd0);
    chk("R8 ready after last pair", {63'd0, cmdReady}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'd4711);
    rstN = 1'b0; cmdValid = 1'b0; cmdAddr = '0; cmdStart = '0; cmdEnd = '0;
    memWrEn = 1'b0; memWrAddr = '0; memWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", {63'd0, cmdReady}, 64'd1);
    chk("R1 no valid in reset", {60'd0, outValid, outLast, outUsedLo, outUsedHi}, 64'd0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 ready after reset", {63'd0, cmdReady}, 64'd1);
    chk("R1 quiet after reset", {60'd0, outValid, outLast, outUsedLo, outUsedHi}, 64'd0);

    for (int a = 0; a < DEPTH; a++) writeWord(a, {$urandom, $urandom});

    // R6: single-beat request at every offset, then open-ended
    for (int s = 0; s < RATIO; s++) doRead(s % DEPTH, s, s, 1'b0);
    for (int s = 0; s < RATIO; s++) doRead((s + 3) % DEPTH, s, RATIO - 1, 1'b0);
    doRead(DEPTH - 1, 0, RATIO - 1, 1'b0);
    // R7: inverted range sends all beats, none used
    doRead(2, 5, 2, 1'b0);
    doRead(7, RATIO - 1, 0, 1'b0);
    // R9: write to the burst address on its capture edge
    doRead(4, 1, 6, 1'b1);
    doRead(4, 0, RATIO - 1, 1'b0);
    doRead(DEPTH - 1, 2, 3, 1'b1);
    doRead(DEPTH - 1, 2, 3, 1'b0);

    for (int n = 0; n < 40; n++) begin
      int a; int s; int e;
      a = int'($urandom_range(DEPTH - 1, 0));
      s = int'($urandom_range(RATIO - 1, 0));
      e = int'($urandom_range(RATIO - 1, 0));
      doRead(a, s, e, (n % 7) == 3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule